// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the host-side register access port of a UART-style peripheral. One static mode pin selects the bus style. In separate-strobe mode, active-low read and write strobes frame each access. In direction-line mode, chip select is the strobe and the write-strobe pin gives the direction. A 3-bit address picks one of eight byte registers, which are held in a small register-file stub. The block drives read data onto the host data bus, captures write data, and issues one-cycle read and write pulses in the internal clock domain.

The data bus is split into an input, an output and an output enable, so the pad ring can form the bidirectional pin. The interrupt pin is also given as a value and a driver enable. In separate-strobe mode it is an active-high output that an enable bit in the control register can tristate. In direction-line mode it is an active-low open-drain output. The strobe pins are asynchronous and pass through two-flop synchronizers before any register is written.

Top module: `hbus_port`

## Requirements
- R1: In separate-strobe mode (`mode_sep`=1), while `cs_n`=0 and `rd_n`=0, `data_oe` is 1 and `data_out` equals the register selected by `addr`.
- R2: In separate-strobe mode, a write with `cs_n`=0 and `wr_n`=0 stores `data_in` into the register at `addr` once `wr_n` rises. Each such access gives exactly one one-cycle `reg_wr` pulse.
- R3: In direction-line mode (`mode_sep`=0), `wr_n`=1 with `cs_n`=0 is a read and drives `data_oe`. `wr_n`=0 with `cs_n`=0 is a write, and that write is committed when `cs_n` rises. `rd_n` has no effect in this mode.
- R4: In direction-line mode, if `wr_n` rises while `cs_n` is still 0, the write is abandoned: no register changes and no `reg_wr` pulse is issued.
- R5: While `cs_n`=1, strobe activity causes no bus drive, no register change and no `reg_rd` or `reg_wr` pulse.
- R6: During an access, `reg_sel` is the one-hot code of `addr` (bit n for address n). Outside an access it is zero. The eight registers are stored independently.
- R7: `data_oe` is 0 during every write and whenever `cs_n`=1.
- R8: In separate-strobe mode, `irq_out` follows `irq_src` (active high). `irq_oe` equals bit 3 of the register at address 4.
- R9: In direction-line mode, `irq_out` is always 0. `irq_oe` is 1 only when `irq_src`=1 and bit 3 of register 4 is 0, so the pin only pulls low or releases.
- R10: After reset, all registers read 0 (so bit 3 of register 4 is 0), `reg_sel` is 0, and `reg_rd`, `reg_wr` and `data_oe` are 0.
- R11: Each read access gives exactly one one-cycle `reg_rd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sep | input | 1 | 1 = separate strobes, 0 = direction line |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe (ignored when mode_sep=0) |
| wr_n | input | 1 | Active-low write strobe, or direction line (1 = read) |
| addr | input | 3 | Register address |
| data_in | input | 8 | Host data bus, incoming |
| data_out | output | 8 | Host data bus, outgoing |
| data_oe | output | 1 | Data bus driver enable |
| irq_src | input | 1 | Internal interrupt request, active high |
| irq_out | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin driver enable |
| reg_sel | output | 8 | One-hot register select during an access |
| reg_rd | output | 1 | One-cycle read pulse |
| reg_wr | output | 1 | One-cycle write pulse |

## Verification
On every cycle, the assertions check four things. The data bus is never driven without chip select or during a write. The open-drain interrupt never drives high. The read and write pulses last one cycle. No write pulse appears after chip select has been idle for several cycles. Only the bench scenarios can show that the right byte lands in the right register, that the direction-line commit waits for chip select to rise, that an abandoned write leaves storage untouched, and that the interrupt enable bit changes the pin drive in each mode.

// File: rtl/hbus_port.sv
module hbus_port #(
  parameter int DW         = 8,
  parameter int AW         = 3,
  parameter int CTRL_ADDR  = 4,
  parameter int IRQ_EN_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_sep,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   data_in,
  output logic [DW-1:0]   data_out,
  output logic            data_oe,
  input  logic            irq_src,
  output logic            irq_out,
  output logic            irq_oe,
  output logic [(1<<AW)-1:0] reg_sel,
  output logic            reg_rd,
  output logic            reg_wr
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];
  logic [1:0] cs_q, rd_q, wr_q;
  logic cs_s, rd_s, wr_s;
  logic rd_act, wr_act, rd_act_q, wr_act_q, commit;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 2'b11;
      rd_q <= 2'b11;
      wr_q <= 2'b11;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      rd_q <= {rd_q[0], rd_n};
      wr_q <= {wr_q[0], wr_n};
    end
  end

  assign cs_s = cs_q[1];
  assign rd_s = rd_q[1];
  assign wr_s = wr_q[1];

  assign rd_act = !cs_s && (mode_sep ? !rd_s : wr_s);
  assign wr_act = !cs_s && !wr_s;
  assign commit = wr_act_q && (mode_sep ? !wr_act : cs_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q  <= 1'b0;
      wr_act_q  <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      reg_rd   <= rd_act && !rd_act_q;
      reg_wr   <= commit;
      if (wr_act) begin
        hold_addr <= addr;
        hold_data <= data_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (commit) begin
      regs[hold_addr] <= hold_data;
    end
  end

  assign reg_sel  = (rd_act || wr_act) ? (NREG'(1) << addr) : '0;
  assign data_out = regs[addr];
  assign data_oe  = !cs_n && (mode_sep ? (!rd_n && wr_n) : wr_n);

  assign irq_en  = regs[CTRL_ADDR][IRQ_EN_BIT];
  assign irq_out = mode_sep ? irq_src : 1'b0;
  assign irq_oe  = mode_sep ? irq_en : (irq_src && !irq_en);
endmodule

module hbus_port_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_sep,
  input logic cs_n,
  input logic rd_n,
  input logic wr_n,
  input logic data_oe,
  input logic irq_out,
  input logic irq_oe,
  input logic reg_rd,
  input logic reg_wr
);
  p_oe_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !cs_n);
  p_no_oe_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && (rd_n || !mode_sep)) |-> !data_oe);
  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  p_od_never_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sep && irq_oe) |-> !irq_out);
  p_idle_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> (!reg_wr && !reg_rd));
endmodule

bind hbus_port hbus_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .cs_n(cs_n), .rd_n(rd_n),
  .wr_n(wr_n), .data_oe(data_oe), .irq_out(irq_out), .irq_oe(irq_oe),
  .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/hbus_port_test.sv
module hbus_port_test;
  logic clk = 0, rst_n = 0, mode_sep = 1, cs_n = 1, rd_n = 1, wr_n = 1, irq_src = 0;
  logic [2:0] addr = 0;
  logic [7:0] data_in = 0, data_out, reg_sel;
  logic data_oe, irq_out, irq_oe, reg_rd, reg_wr;
  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0] model [8];

  hbus_port uut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (reg_wr) wr_cnt++;
    if (reg_rd) rd_cnt++;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sep_write(input logic [2:0] a, input logic [7:0] d);
    int w0 = wr_cnt;
    addr = a; data_in = d; cyc(1);
    cs_n = 0; wr_n = 0; cyc(2);
    chk(data_oe == 0, "R7 oe during sep write", data_oe, 0);
    chk(reg_sel == (8'd1 << a), "R6 select during write", reg_sel, 8'd1 << a);
    cyc(2); wr_n = 1; cyc(1); cs_n = 1; cyc(5);
    model[a] = d;
    chk(wr_cnt == w0 + 1, "R2 one write pulse", wr_cnt - w0, 1);
    chk(reg_sel == 0, "R6 select idle", reg_sel, 0);
  endtask

  task automatic sep_read(input logic [2:0] a, input string tag);
    int r0 = rd_cnt;
    addr = a; cyc(1);
    cs_n = 0; rd_n = 0; cyc(1);
    chk(data_oe == 1, {tag, " oe"}, data_oe, 1);
    chk(data_out == model[a], tag, data_out, model[a]);
    cyc(3); rd_n = 1; cs_n = 1; cyc(5);
    chk(rd_cnt == r0 + 1, "R11 one read pulse", rd_cnt - r0, 1);
    chk(data_oe == 0, "R7 oe after read", data_oe, 0);
  endtask

  task automatic dir_write(input logic [2:0] a, input logic [7:0] d);
    int w0 = wr_cnt;
    addr = a; data_in = d; wr_n = 0; cyc(1);
    cs_n = 0; rd_n = 0; cyc(4);
    chk(data_oe == 0, "R3 no drive on dir write with rd_n low", data_oe, 0);
    chk(wr_cnt == w0, "R3 no commit before cs rise", wr_cnt - w0, 0);
    cs_n = 1; cyc(1); wr_n = 1; rd_n = 1; cyc(5);
    model[a] = d;
    chk(wr_cnt == w0 + 1, "R3 one write pulse on cs rise", wr_cnt - w0, 1);
  endtask

  task automatic dir_read(input logic [2:0] a, input string tag);
    int r0 = rd_cnt;
    addr = a; wr_n = 1; rd_n = 1; cyc(1);
    cs_n = 0; cyc(1);
    chk(data_oe == 1, {tag, " oe"}, data_oe, 1);
    chk(data_out == model[a], tag, data_out, model[a]);
    cyc(4); cs_n = 1; cyc(5);
    chk(rd_cnt == r0 + 1, "R11 one dir read pulse", rd_cnt - r0, 1);
  endtask

  task automatic test_reset;
    chk(reg_sel == 0, "R10 reset select", reg_sel, 0);
    chk(!reg_rd && !reg_wr && !data_oe, "R10 reset pulses", {reg_rd, reg_wr, data_oe}, 0);
    for (int i = 0; i < 8; i++) model[i] = 0;
    sep_read(3'd4, "R10 ctrl reads zero");
  endtask

  task automatic test_sep_rw;
    for (int i = 0; i < 8; i++) sep_write(i[2:0], 8'h31 + 8'(i * 17));
    for (int i = 0; i < 8; i++) sep_read(i[2:0], "R1 sep readback R6");
  endtask

  task automatic test_deselected;
    int w0 = wr_cnt, r0 = rd_cnt;
    addr = 3'd2; data_in = 8'hEE; cs_n = 1;
    rd_n = 0; cyc(3);
    chk(data_oe == 0, "R5 no drive deselected", data_oe, 0);
    rd_n = 1; wr_n = 0; cyc(3); wr_n = 1; cyc(6);
    chk(wr_cnt == w0 && rd_cnt == r0, "R5 no pulses", wr_cnt - w0 + rd_cnt - r0, 0);
    sep_read(3'd2, "R5 register unchanged");
  endtask

  task automatic test_sep_irq;
    irq_src = 1; cyc(1);
    chk(irq_oe == 0 && irq_out == 1, "R8 disabled tristate", {irq_oe, irq_out}, 1);
    sep_write(3'd4, 8'h08); cyc(1);
    chk(irq_oe == 1 && irq_out == 1, "R8 enabled high", {irq_oe, irq_out}, 3);
    irq_src = 0; cyc(1);
    chk(irq_oe == 1 && irq_out == 0, "R8 enabled low", {irq_oe, irq_out}, 2);
  endtask

  task automatic test_dir;
    mode_sep = 0; cyc(3);
    dir_write(3'd4, 8'h00);
    irq_src = 1; cyc(1);
    chk(irq_oe == 1 && irq_out == 0, "R9 pull low", {irq_oe, irq_out}, 2);
    irq_src = 0; cyc(1);
    chk(irq_oe == 0, "R9 release", irq_oe, 0);
    dir_write(3'd4, 8'h08); irq_src = 1; cyc(1);
    chk(irq_oe == 0 && irq_out == 0, "R9 bit3 set releases", {irq_oe, irq_out}, 0);
    irq_src = 0;
    dir_write(3'd6, 8'hA5);
    dir_read(3'd6, "R3 dir readback");
    dir_read(3'd1, "R3 dir other reg");
    addr = 3'd1; wr_n = 1; rd_n = 0; cs_n = 1; cyc(3);
    chk(data_oe == 0, "R3 rd_n ignored deselected", data_oe, 0);
    cs_n = 0; cyc(1); rd_n = 1; cyc(1);
    chk(data_oe == 1, "R3 rd_n ignored read", data_oe, 1);
    cs_n = 1; cyc(5);
  endtask

  task automatic test_abandon;
    int w0 = wr_cnt;
    addr = 3'd6; data_in = 8'h5A; wr_n = 0; cyc(1);
    cs_n = 0; cyc(4); wr_n = 1; cyc(4); cs_n = 1; cyc(6);
    chk(wr_cnt == w0, "R4 abandoned no pulse", wr_cnt - w0, 0);
    dir_read(3'd6, "R4 register kept");
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    test_reset;
    test_sep_rw;
    test_deselected;
    test_sep_irq;
    test_dir;
    test_abandon;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule